// File: doc/BRIEF.md
# Debug Access Level Controller

This block decides how much an external debugger may reach at any moment. It follows the boot progression from reset through ROM execution and handoff into user software. It keeps a one-bit debug lock that is set from the very first cycle after reset, and it checks password attempts against a reference value. It decides whether a request to enter debug mode is honoured, based on the current privilege level and on one break-enable bit per privilege level.

From these it drives three outputs: the granted access level, a registered debug-mode flag, and the effective privilege level. Full access is only offered while the system is still in its early boot window.

After a fixed number of wrong passwords, every further attempt is refused until the next reset.

Top module: `dbg_access_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it ends, the outputs are: `stage_o`=0, `lock_o`=1, `lvl_o`=0, `dbg_mode_o`=0, and `priv_o` equal to `priv_i`.
- R2: Each clock edge that sees `stage_adv_i`=1 moves `stage_o` one step forward, in the order 0 (reset) → 1 (ROM) → 2 (handoff) → 3 (user). The stage never moves back before the next reset, and it holds at 3.
- R3: `lock_o`=1 means the debugger is disabled and 0 means it is enabled. The lock clears on the edge after an attempt (`pwd_valid_i`=1) whose `pwd_i` equals `pwd_ref_i`. A wrong attempt leaves the lock unchanged.
- R4: `lvl_o` is derived from the lock and the current stage, and it changes in the same cycle as either one:
  - 0 (none) while locked.
  - 2 (full) while unlocked in stage 0 or 1.
  - 1 (user-debug) while unlocked in stage 2 or 3.
- R5: `dbg_mode_o` rises on the edge after `dbg_req_i`=1, but only when all of the following hold:
  - The block is unlocked.
  - Either `priv_i`=3 (machine) with `brk_en_m_i`=1, or `priv_i`=0 (user) with `brk_en_u_i`=1.
  - Any other privilege value is refused.
- R6: While in debug mode, `dbg_exit_i`=1 clears `dbg_mode_o` on the next edge.
- R7: `priv_o` is 3 while `dbg_mode_o`=1 and equals `priv_i` otherwise. A correct password alone does not raise it.
- R8: Each wrong attempt counts as a failure. After 3 failures, every attempt is ignored until reset, including a correct one.
- R9: Once the stage reaches 3, level 2 is never granted, even when the block is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_adv_i | input | 1 | Advance boot stage by one step |
| pwd_valid_i | input | 1 | Password attempt strobe |
| pwd_i | input | PW_W | Presented password |
| pwd_ref_i | input | PW_W | Reference password |
| dbg_req_i | input | 1 | Debug-mode entry request |
| dbg_exit_i | input | 1 | Debug-mode exit request |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| brk_en_m_i | input | 1 | Machine-mode break enable |
| brk_en_u_i | input | 1 | User-mode break enable |
| stage_o | output | 2 | Current boot stage |
| lock_o | output | 1 | Debug lock (1 = debugger disabled) |
| lvl_o | output | 2 | Granted access level |
| dbg_mode_o | output | 1 | Debug mode active |
| priv_o | output | 2 | Effective privilege |

## Verification
The bench builds the block with `PW_W`=16 and `MAX_FAIL`=3. With these values the failure lockout is reached after three wrong attempts, so both the lockout and its clearing by reset fall within a short run.

A behavioural model shadows the stage, the lock, the failure count and the debug flag, and its expected outputs are compared with the block's outputs on every cycle. The stimulus walks every boot stage while unlocked, to show the full level disappearing, and it requests debug entry at each privilege value with the break-enable bits both set and cleared.

// File: rtl/dbg_access_pkg.sv
// Package: shared encodings for the debug access level controller.
// Assumes a 2-bit privilege encoding with user = 0 and machine = 3.
package dbg_access_pkg;
    typedef enum logic [1:0] {
        ST_RESET   = 2'd0,
        ST_ROM     = 2'd1,
        ST_HANDOFF = 2'd2,
        ST_USER    = 2'd3
    } boot_stage_e;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_USER = 2'd1,
        LVL_FULL = 2'd2
    } acc_lvl_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_M = 2'd3;
endpackage

// File: rtl/boot_stage_fsm.sv
// Module: boot_stage_fsm
// Tracks the boot stage. It moves forward one step per advance pulse,
// saturates at the user stage, and returns to the reset stage only on reset.
// Assumes the advance input is synchronous to clk.
module boot_stage_fsm
    import dbg_access_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv_i,
    output boot_stage_e stage_o
);
    boot_stage_e stage_q;

    // Forward-only stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= ST_RESET;
        end else if (adv_i && stage_q != ST_USER) begin
            stage_q <= boot_stage_e'(stage_q + 2'd1);
        end
    end

    assign stage_o = stage_q;

    // R2: the stage never moves backwards between resets.
    p_stage_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q >= $past(stage_q));

    // R2: with no advance pulse, the stage holds.
    p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(stage_q));
endmodule

// File: rtl/dbg_auth.sv
// Module: dbg_auth
// Holds the debug lock bit (1 = disabled), which is set on reset. It clears
// the lock on a correct password attempt and counts wrong attempts, refusing
// all attempts once MAX_FAIL failures have been seen.
// Assumes the reference password is stable while attempts are made.
module dbg_auth #(
    parameter int PW_W     = 16,
    parameter int MAX_FAIL = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwd_valid_i,
    input  logic [PW_W-1:0] pwd_i,
    input  logic [PW_W-1:0] pwd_ref_i,
    output logic            lock_o
);
    localparam int FAIL_W = $clog2(MAX_FAIL + 1);
    localparam logic [FAIL_W-1:0] FAIL_LIM = FAIL_W'(MAX_FAIL);

    logic              lock_q;
    logic [FAIL_W-1:0] fail_q;
    logic              blocked;
    logic              try_ok;
    logic              try_bad;

    // Decode the current attempt into success or failure.
    always_comb begin
        blocked = (fail_q >= FAIL_LIM);
        try_ok  = pwd_valid_i && !blocked && (pwd_i == pwd_ref_i);
        try_bad = pwd_valid_i && !blocked && (pwd_i != pwd_ref_i);
    end

    // Lock bit: secure from reset, cleared only by a successful attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b1;
        end else if (try_ok) begin
            lock_q <= 1'b0;
        end
    end

    // Failure counter, saturating at the lockout limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= '0;
        end else if (try_bad) begin
            fail_q <= fail_q + 1'b1;
        end
    end

    assign lock_o = lock_q;

    // R3: the lock only falls after a matching attempt.
    p_unlock_auth_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> $past(pwd_valid_i && (pwd_i == pwd_ref_i)));

    // R3: once cleared, the lock stays clear until reset.
    p_lock_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |=> !lock_q);

    // R8: the failure count never passes the limit.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_q <= FAIL_LIM);

    // R8: an attempt made after lockout leaves the lock unchanged.
    p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && pwd_valid_i) |=> $stable(lock_q));
endmodule

// File: rtl/dbg_mode_ctrl.sv
// Module: dbg_mode_ctrl
// Registers the debug-mode flag, entered on a request that meets the
// privilege and lock conditions and left on an exit request. Also derives the
// granted access level and the effective privilege.
// Assumes the stage and lock inputs come from registers.
module dbg_mode_ctrl
    import dbg_access_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  boot_stage_e stage_i,
    input  logic        lock_i,
    input  logic        dbg_req_i,
    input  logic        dbg_exit_i,
    input  logic [1:0]  priv_i,
    input  logic        brk_en_m_i,
    input  logic        brk_en_u_i,
    output acc_lvl_e    lvl_o,
    output logic        dbg_mode_o,
    output logic [1:0]  priv_o
);
    logic dbg_q;
    logic dbg_d;
    logic priv_ok;

    // Granted level from the lock and boot stage; full access only early.
    always_comb begin
        if (lock_i) begin
            lvl_o = LVL_NONE;
        end else if (stage_i == ST_RESET || stage_i == ST_ROM) begin
            lvl_o = LVL_FULL;
        end else begin
            lvl_o = LVL_USER;
        end
    end

    // Next debug-mode state from the request, privilege, enables and lock.
    always_comb begin
        priv_ok = ((priv_i == PRIV_M) && brk_en_m_i) ||
                  ((priv_i == PRIV_U) && brk_en_u_i);
        if (dbg_q) begin
            dbg_d = !dbg_exit_i;
        end else begin
            dbg_d = dbg_req_i && !lock_i && (lvl_o != LVL_NONE) && priv_ok;
        end
    end

    // Debug-mode flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_q <= 1'b0;
        end else begin
            dbg_q <= dbg_d;
        end
    end

    assign dbg_mode_o = dbg_q;
    assign priv_o     = dbg_q ? PRIV_M : priv_i;

    // R5: debug mode is only entered after an authorized request.
    p_dbg_auth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_q) |-> $past(dbg_req_i && !lock_i));

    // R6: an exit request always leaves debug mode.
    p_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_q && dbg_exit_i) |=> !dbg_q);

    // R7: privilege is only raised while in debug mode.
    p_priv_elev_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_o == PRIV_M && priv_i != PRIV_M) |-> dbg_q);

    // R4 and R9: full access appears only in the early boot stages.
    p_full_early_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o == LVL_FULL) |-> (stage_i == ST_RESET || stage_i == ST_ROM));
endmodule

// File: rtl/dbg_access_ctrl.sv
// Module: dbg_access_ctrl (top)
// Connects the boot stage tracker, the password and lock unit, and the
// debug-mode controller, and decides the debug access granted to an
// external debugger.
// Assumes all inputs are synchronous to clk.
module dbg_access_ctrl #(
    parameter int PW_W     = 16,
    parameter int MAX_FAIL = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stage_adv_i,
    input  logic            pwd_valid_i,
    input  logic [PW_W-1:0] pwd_i,
    input  logic [PW_W-1:0] pwd_ref_i,
    input  logic            dbg_req_i,
    input  logic            dbg_exit_i,
    input  logic [1:0]      priv_i,
    input  logic            brk_en_m_i,
    input  logic            brk_en_u_i,
    output logic [1:0]      stage_o,
    output logic            lock_o,
    output logic [1:0]      lvl_o,
    output logic            dbg_mode_o,
    output logic [1:0]      priv_o
);
    import dbg_access_pkg::*;

    boot_stage_e stage;
    acc_lvl_e    lvl;
    logic        lock;

    boot_stage_fsm u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (stage_adv_i),
        .stage_o (stage)
    );

    dbg_auth #(
        .PW_W     (PW_W),
        .MAX_FAIL (MAX_FAIL)
    ) u_auth (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwd_valid_i (pwd_valid_i),
        .pwd_i       (pwd_i),
        .pwd_ref_i   (pwd_ref_i),
        .lock_o      (lock)
    );

    dbg_mode_ctrl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage_i    (stage),
        .lock_i     (lock),
        .dbg_req_i  (dbg_req_i),
        .dbg_exit_i (dbg_exit_i),
        .priv_i     (priv_i),
        .brk_en_m_i (brk_en_m_i),
        .brk_en_u_i (brk_en_u_i),
        .lvl_o      (lvl),
        .dbg_mode_o (dbg_mode_o),
        .priv_o     (priv_o)
    );

    assign stage_o = stage;
    assign lock_o  = lock;
    assign lvl_o   = lvl;
endmodule

// File: tb/dbg_access_ctrl_tb.sv
module dbg_access_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PW_W       = 16;
    localparam int MAX_FAIL   = 3;
    localparam logic [PW_W-1:0] KEY = 16'hC0DE;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            stage_adv_i = 1'b0;
    logic            pwd_valid_i = 1'b0;
    logic [PW_W-1:0] pwd_i = '0;
    logic [PW_W-1:0] pwd_ref_i = KEY;
    logic            dbg_req_i = 1'b0;
    logic            dbg_exit_i = 1'b0;
    logic [1:0]      priv_i = 2'd0;
    logic            brk_en_m_i = 1'b0;
    logic            brk_en_u_i = 1'b0;
    logic [1:0]      stage_o;
    logic            lock_o;
    logic [1:0]      lvl_o;
    logic            dbg_mode_o;
    logic [1:0]      priv_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // Reference model state.
    int m_stage = 0;
    int m_lock = 1;
    int m_fails = 0;
    int m_dbg = 0;

    dbg_access_ctrl #(.PW_W(PW_W), .MAX_FAIL(MAX_FAIL)) u_dut (
        .clk(clk), .rst_n(rst_n), .stage_adv_i(stage_adv_i),
        .pwd_valid_i(pwd_valid_i), .pwd_i(pwd_i), .pwd_ref_i(pwd_ref_i),
        .dbg_req_i(dbg_req_i), .dbg_exit_i(dbg_exit_i), .priv_i(priv_i),
        .brk_en_m_i(brk_en_m_i), .brk_en_u_i(brk_en_u_i),
        .stage_o(stage_o), .lock_o(lock_o), .lvl_o(lvl_o),
        .dbg_mode_o(dbg_mode_o), .priv_o(priv_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_lvl();
        if (m_lock != 0) return 0;
        if (m_stage <= 1) return 2;
        return 1;
    endfunction

    // Model update on every edge, from the inputs as the design sees them.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_stage = 0; m_lock = 1; m_fails = 0; m_dbg = 0;
        end else begin
            int ok;
            ok = ((priv_i == 2'd3) && brk_en_m_i) || ((priv_i == 2'd0) && brk_en_u_i);
            if (m_dbg != 0) m_dbg = dbg_exit_i ? 0 : 1;
            else m_dbg = (dbg_req_i && m_lock == 0 && ok) ? 1 : 0;
            if (pwd_valid_i && m_fails < MAX_FAIL) begin
                if (pwd_i == pwd_ref_i) m_lock = 0;
                else m_fails++;
            end
            if (stage_adv_i && m_stage < 3) m_stage++;
        end
    end

    // Compare against the model at every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            check("R2 stage", int'(stage_o), m_stage);
            check("R3 lock", int'(lock_o), m_lock);
            check("R4 level", int'(lvl_o), exp_lvl());
            check("R5 dbg_mode", int'(dbg_mode_o), m_dbg);
            check("R7 priv", int'(priv_o), m_dbg != 0 ? 3 : int'(priv_i));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
            stage_adv_i = 0; pwd_valid_i = 0; dbg_req_i = 0; dbg_exit_i = 0;
        end
    endtask

    task automatic attempt(input logic [PW_W-1:0] p);
        pwd_i = p; pwd_valid_i = 1; step();
    endtask

    task automatic do_reset();
        rst_n = 0; step(3); rst_n = 1; step();
    endtask

    initial begin
        do_reset();
        @(negedge clk); #1;
        check("R1 stage", int'(stage_o), 0);
        check("R1 lock", int'(lock_o), 1);
        check("R1 level", int'(lvl_o), 0);
        check("R1 dbg_mode", int'(dbg_mode_o), 0);
        step();
        // A request while locked is refused.
        priv_i = 2'd3; brk_en_m_i = 1; dbg_req_i = 1; step(2);
        check("R5 locked refuse", int'(dbg_mode_o), 0);
        attempt(16'h1234); step();
        check("R3 wrong keeps lock", int'(lock_o), 1);
        attempt(KEY); step();
        check("R3 unlock", int'(lock_o), 0);
        check("R4 full early", int'(lvl_o), 2);
        priv_i = 2'd0; step();
        check("R7 no elevation by password", int'(priv_o), 0);
        // Machine mode with its enable cleared.
        priv_i = 2'd3; brk_en_m_i = 0; dbg_req_i = 1; step(2);
        check("R5 brk_m off", int'(dbg_mode_o), 0);
        brk_en_m_i = 1; dbg_req_i = 1; step();
        check("R5 enter machine", int'(dbg_mode_o), 1);
        priv_i = 2'd0; step();
        check("R7 raised in debug", int'(priv_o), 3);
        dbg_exit_i = 1; step();
        check("R6 exit", int'(dbg_mode_o), 0);
        // User mode, with and without its enable.
        brk_en_u_i = 0; dbg_req_i = 1; step(2);
        check("R5 brk_u off", int'(dbg_mode_o), 0);
        brk_en_u_i = 1; dbg_req_i = 1; step();
        check("R5 enter user", int'(dbg_mode_o), 1);
        dbg_exit_i = 1; step();
        check("R6 exit user", int'(dbg_mode_o), 0);
        priv_i = 2'd1; brk_en_m_i = 1; dbg_req_i = 1; step(2);
        check("R5 supervisor refused", int'(dbg_mode_o), 0);
        // Walk through the stages.
        stage_adv_i = 1; step();
        check("R4 full in ROM", int'(lvl_o), 2);
        stage_adv_i = 1; step();
        check("R4 user level at handoff", int'(lvl_o), 1);
        stage_adv_i = 1; step();
        check("R9 no full in user stage", int'(lvl_o), 1);
        stage_adv_i = 1; step(); stage_adv_i = 1; step();
        check("R2 saturate", int'(stage_o), 3);
        priv_i = 2'd0; dbg_req_i = 1; step(2);
        check("R9 user debug still allowed", int'(dbg_mode_o), 1);
        dbg_exit_i = 1; step();
        // Lockout after three failures.
        do_reset();
        attempt(16'h0001); attempt(16'h0002); attempt(16'h0003);
        attempt(KEY); step();
        check("R8 blocked after failures", int'(lock_o), 1);
        check("R8 level none", int'(lvl_o), 0);
        do_reset();
        attempt(KEY); step();
        check("R8 cleared by reset", int'(lock_o), 0);
        step(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule